// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block turns a short packet held in a byte source into the line signalling of a low-speed USB link. A one-clock start request carries a byte count. The block then takes the bus while showing the idle level, and emits a synchronisation byte that it generates itself. After that it sends the payload bytes, least significant bit first. The bits are NRZI coded, and a stuffed bit is added after every run of six ones. The packet closes with an end-of-packet sequence, after which the bus is handed back.

Payload bytes come from a show-ahead source. `byte_data` always presents the next byte, and a one-clock `byte_req` pulse consumes it. The request is raised while the last bit of the current byte is on the line, so bytes follow each other with no gap. When the bus has been released, `done` pulses. With it, `addr_commit` tells the device whether a pending address change may take effect now. That is allowed only after a data packet, not after a two-byte handshake.

Top module: `lsusb_tx`

## Requirements
- R1: During and after reset, with no start request, `usb_oe`, `usb_dp`, `usb_dm`, `done`, `addr_commit` and `byte_req` are all low.
- R2: Taking the bus happens in two steps:
  - In the clock after an accepted start, the lines show J (`usb_dp`=0, `usb_dm`=1) while `usb_oe` is still low.
  - `usb_oe` then rises, and J is driven for one bit time before the first coded bit.
- R3: Every line symbol lasts exactly CLKS_PER_BIT clocks (10 by default). The end-of-packet SE0 lasts exactly two bit times.
- R4: The count covers both the generated sync byte and the payload:
  - The first byte sent is 0x80, least significant bit first, and it is generated inside the block.
  - `byte_count` includes this sync byte, so exactly count-1 payload bytes are fetched and sent, each least significant bit first.
- R5: NRZI coding: a 0 bit toggles the line between J and K, and a 1 bit holds the line. J is `usb_dp`=0, `usb_dm`=1. K is `usb_dp`=1, `usb_dm`=0.
- R6: Stuffing rules:
  - After six consecutive 1 bits, a stuffed 0 (one extra toggle) is sent before the next bit. This also applies across byte boundaries and after the final data bit.
  - Any 0 restarts the run of ones, and that includes a stuffed 0.
- R7: `byte_req` is a one-clock pulse. It is raised in the clock after the last bit of a byte starts, and only when payload bytes remain. `byte_data` is taken on the clock edge that ends the pulse.
- R8: After the last bit (including any stuffed bit), the block drives SE0 (both lines low, `usb_oe` high) for two bit times, then J for one bit time. It then drops `usb_oe` and drives both lines low.
- R9: `done` is high for exactly one clock: the first clock in which `usb_oe` is low again.
- R10: `addr_commit` pulses together with `done` only when the effective byte count is greater than 2.
- R11: A start request made while a packet is in progress has no effect on the line output or on the number of bytes fetched.
- R12: A `byte_count` below 2 is treated as 2, and a count above 12 is treated as 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request to send a packet; honoured only when idle |
| byte_count | input | COUNT_W | Total bytes including the sync byte, sampled with `start` |
| byte_data | input | 8 | Next payload byte from a show-ahead source |
| byte_req | output | 1 | One-clock pulse consuming `byte_data` |
| usb_dp | output | 1 | D+ line level |
| usb_dm | output | 1 | D- line level |
| usb_oe | output | 1 | Output enable for both lines |
| done | output | 1 | One-clock pulse after the bus is released |
| addr_commit | output | 1 | One-clock pulse with `done` after a data packet |

## Verification
Any fault in the bit timer, the stuffing run counter, the NRZI level or the byte shifter shows up at the pins within one bit time. Such a fault lengthens or shortens a symbol, or flips J and K for every symbol after the fault. For that reason the bench compares the full line state on every clock of each packet against a model built from the requirements. A fault in the byte bookkeeping appears either as a wrong payload bit at the next byte boundary or as a misplaced end-of-packet. A fault in the end-of-packet sequencing shows as wrong timing of `done` and `addr_commit`, at most three bit times after the last data bit.

// File: rtl/lsusb_tx_pkg.sv
package lsusb_tx_pkg;

  // Transmit sequencer phases, in the order a packet passes through them.
  typedef enum logic [2:0] {
    TX_IDLE,   // bus released, lines low
    TX_ARM,    // idle levels set up, drivers still off
    TX_LEAD,   // drivers on, one bit of J ahead of the sync byte
    TX_DATA,   // coded bits and stuffed bits
    TX_SE0,    // two bit times of single-ended zero
    TX_EOPJ    // one bit time of J before release
  } tx_state_e;

  // Sync byte, shifted out least significant bit first.
  localparam logic [7:0] SYNC_PATTERN = 8'h80;

  typedef struct packed {
    logic oe;
    logic dp;
    logic dm;
  } line_drive_t;

endpackage

// File: rtl/lsusb_bit_timer.sv
module lsusb_bit_timer #(
  parameter int CLKS_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bit_end
);

  localparam int TW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLKS_PER_BIT - 1);
  localparam logic [TW-1:0] STEP = TW'(1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_end = run && (cnt_q == LAST);

endmodule

// File: rtl/lsusb_byte_feed.sv
module lsusb_byte_feed
  import lsusb_tx_pkg::*;
#(
  parameter int COUNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_count,
  input  logic               emit,
  input  logic [7:0]         byte_data,
  output logic               cur_bit,
  output logic               empty,
  output logic               byte_req
);

  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic [7:0]         sh_q, sh_d;
  logic [2:0]         pos_q, pos_d;
  logic [COUNT_W-1:0] left_q, left_d;
  logic               empty_q, empty_d;
  logic               req_q, req_d;

  always_comb begin
    sh_d    = sh_q;
    pos_d   = pos_q;
    left_d  = left_q;
    empty_d = empty_q;
    req_d   = 1'b0;
    if (load) begin
      sh_d    = SYNC_PATTERN;
      pos_d   = '0;
      left_d  = load_count - ONE;
      empty_d = 1'b0;
    end else begin
      // The shifter is idle while the request is out: its last bit is on the line.
      if (req_q) sh_d = byte_data;
      if (emit) begin
        sh_d  = {1'b0, sh_q[7:1]};
        pos_d = pos_q + 3'd1;
        if (pos_q == 3'd7) begin
          if (left_q != '0) begin
            req_d  = 1'b1;
            left_d = left_q - ONE;
          end else begin
            empty_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      pos_q   <= '0;
      left_q  <= '0;
      empty_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      pos_q   <= pos_d;
      left_q  <= left_d;
      empty_q <= empty_d;
      req_q   <= req_d;
    end
  end

  assign cur_bit  = sh_q[0];
  assign empty    = empty_q;
  assign byte_req = req_q;

endmodule

// File: rtl/lsusb_nrzi_stuff.sv
module lsusb_nrzi_stuff #(
  parameter int STUFF_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic stuff_slot,
  input  logic data_slot,
  input  logic data_bit,
  output logic level_k,
  output logic stuff_due
);

  localparam int RW = $clog2(STUFF_LEN + 1);
  localparam logic [RW-1:0] LIMIT = RW'(STUFF_LEN);
  localparam logic [RW-1:0] STEP  = RW'(1);

  logic [RW-1:0] run_q, run_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    run_d = run_q;
    lvl_d = lvl_q;
    if (clear) begin
      run_d = '0;
      lvl_d = 1'b0;
    end else if (stuff_slot) begin
      run_d = '0;
      lvl_d = ~lvl_q;
    end else if (data_slot) begin
      if (data_bit) begin
        run_d = run_q + STEP;
      end else begin
        run_d = '0;
        lvl_d = ~lvl_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      run_q <= run_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_k   = lvl_q;
  assign stuff_due = (run_q == LIMIT);

endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
  import lsusb_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int MIN_BYTES    = 2,
  parameter int MAX_BYTES    = 12,
  parameter int COUNT_W      = 4,
  parameter int STUFF_LEN    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COUNT_W-1:0] byte_count,
  input  logic [7:0]         byte_data,
  output logic               byte_req,
  output logic               usb_dp,
  output logic               usb_dm,
  output logic               usb_oe,
  output logic               done,
  output logic               addr_commit
);

  localparam logic [COUNT_W-1:0] CNT_LO = COUNT_W'(MIN_BYTES);
  localparam logic [COUNT_W-1:0] CNT_HI = COUNT_W'(MAX_BYTES);

  tx_state_e          state_q, state_d;
  logic               se0_second_q, se0_second_d;
  logic               long_q, long_d;
  logic               done_q, done_d;
  logic               commit_q, commit_d;
  logic [COUNT_W-1:0] eff_count;
  logic               accept, timer_run, bit_end;
  logic               in_stream, stuff_slot, data_slot, to_se0;
  logic               cur_bit, empty, level_k, stuff_due;
  line_drive_t        drive;

  // Out-of-range counts are pulled into the supported window.
  always_comb begin
    if (byte_count < CNT_LO)      eff_count = CNT_LO;
    else if (byte_count > CNT_HI) eff_count = CNT_HI;
    else                          eff_count = byte_count;
  end

  assign accept    = (state_q == TX_IDLE) && start;
  assign timer_run = (state_q != TX_IDLE) && (state_q != TX_ARM);
  assign in_stream = (state_q == TX_LEAD) || (state_q == TX_DATA);

  // A due stuffed bit always wins over both the next data bit and the end of packet.
  assign stuff_slot = in_stream && bit_end && stuff_due;
  assign data_slot  = in_stream && bit_end && !stuff_due && !empty;
  assign to_se0     = (state_q == TX_DATA) && bit_end && !stuff_due && empty;

  lsusb_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timer_run),
    .bit_end (bit_end)
  );

  lsusb_byte_feed #(.COUNT_W(COUNT_W)) u_feed (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_count (eff_count),
    .emit       (data_slot),
    .byte_data  (byte_data),
    .cur_bit    (cur_bit),
    .empty      (empty),
    .byte_req   (byte_req)
  );

  lsusb_nrzi_stuff #(.STUFF_LEN(STUFF_LEN)) u_coder (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept),
    .stuff_slot (stuff_slot),
    .data_slot  (data_slot),
    .data_bit   (cur_bit),
    .level_k    (level_k),
    .stuff_due  (stuff_due)
  );

  // Next-state logic.
  always_comb begin
    state_d      = state_q;
    se0_second_d = se0_second_q;
    long_d       = long_q;
    done_d       = 1'b0;
    commit_d     = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (accept) begin
          state_d = TX_ARM;
          long_d  = (eff_count > CNT_LO);
        end
      end
      TX_ARM:  state_d = TX_LEAD;
      TX_LEAD: if (bit_end) state_d = TX_DATA;
      TX_DATA: begin
        if (to_se0) begin
          state_d      = TX_SE0;
          se0_second_d = 1'b0;
        end
      end
      TX_SE0: begin
        if (bit_end) begin
          if (se0_second_q) state_d = TX_EOPJ;
          else              se0_second_d = 1'b1;
        end
      end
      TX_EOPJ: begin
        if (bit_end) begin
          state_d  = TX_IDLE;
          done_d   = 1'b1;
          commit_d = long_q;
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= TX_IDLE;
      se0_second_q <= 1'b0;
      long_q       <= 1'b0;
      done_q       <= 1'b0;
      commit_q     <= 1'b0;
    end else begin
      state_q      <= state_d;
      se0_second_q <= se0_second_d;
      long_q       <= long_d;
      done_q       <= done_d;
      commit_q     <= commit_d;
    end
  end

  // Line decode from registered state only.
  always_comb begin
    drive = '{oe: 1'b0, dp: 1'b0, dm: 1'b0};
    unique case (state_q)
      TX_ARM:           drive = '{oe: 1'b0, dp: 1'b0, dm: 1'b1};
      TX_LEAD, TX_DATA: drive = '{oe: 1'b1, dp: level_k, dm: ~level_k};
      TX_SE0:           drive = '{oe: 1'b1, dp: 1'b0, dm: 1'b0};
      TX_EOPJ:          drive = '{oe: 1'b1, dp: 1'b0, dm: 1'b1};
      default:          drive = '{oe: 1'b0, dp: 1'b0, dm: 1'b0};
    endcase
  end

  assign usb_oe      = drive.oe;
  assign usb_dp      = drive.dp;
  assign usb_dm      = drive.dm;
  assign done        = done_q;
  assign addr_commit = commit_q;

endmodule

// File: rtl/lsusb_tx_chk.sv
module lsusb_tx_chk #(
  parameter int CLKS_PER_BIT = 10,
  parameter int STUFF_LEN    = 6
) (
  input logic clk,
  input logic rst_n,
  input logic usb_dp,
  input logic usb_dm,
  input logic usb_oe,
  input logic done,
  input logic addr_commit,
  input logic byte_req
);

  localparam int MAX_HOLD = (STUFF_LEN + 1) * CLKS_PER_BIT;

  logic [2:0] sym_q;
  int         hold_q;
  logic [2:0] sym_now;

  assign sym_now = {usb_oe, usb_dp, usb_dm};

  // Length of the current run of an unchanged line state, counted from 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q  <= 3'b000;
      hold_q <= 0;
    end else begin
      sym_q <= sym_now;
      if (sym_now != sym_q)    hold_q <= 1;
      else if (hold_q < 100000) hold_q <= hold_q + 1;
    end
  end

  p_take_bus_j_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_oe) |-> (usb_dm && !usb_dp && $past(usb_dm) && !$past(usb_dp)));

  // R3: a driven symbol ends only on a whole number of bit times.
  p_symbol_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_oe && sym_q[2] && (sym_now != sym_q)) |->
      ((hold_q % CLKS_PER_BIT) == 0 && hold_q != 0));

  p_no_both_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    usb_oe |-> !(usb_dp && usb_dm));

  p_stuff_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_oe && (usb_dp ^ usb_dm)) |-> (hold_q <= MAX_HOLD));

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !byte_req);

  p_req_on_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> usb_oe);

  p_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!usb_oe && !usb_dp && !usb_dm && $past(usb_oe)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_commit_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_commit |-> done);

endmodule

bind lsusb_tx lsusb_tx_chk #(
  .CLKS_PER_BIT (CLKS_PER_BIT),
  .STUFF_LEN    (STUFF_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .usb_dp      (usb_dp),
  .usb_dm      (usb_dm),
  .usb_oe      (usb_oe),
  .done        (done),
  .addr_commit (addr_commit),
  .byte_req    (byte_req)
);

// File: tb/tb_lsusb_tx.sv
`timescale 1ns/100ps
module tb_lsusb_tx;
  localparam int CW = 4;

  logic          clk, rst_n, start;
  logic [CW-1:0] byte_count;
  logic [7:0]    byte_data;
  logic          byte_req, usb_dp, usb_dm, usb_oe, done, addr_commit;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;
  logic lvl_seq [0:191];
  int   nsym;
  int   pl [0:15];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  lsusb_tx dut (
    .clk (clk), .rst_n (rst_n), .start (start), .byte_count (byte_count),
    .byte_data (byte_data), .byte_req (byte_req), .usb_dp (usb_dp),
    .usb_dm (usb_dm), .usb_oe (usb_oe), .done (done), .addr_commit (addr_commit)
  );

  task automatic expect_vec(string tag, int cyc, logic [5:0] act, logic [5:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d got %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_int(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Symbol levels (1 = K) for sync + payload after stuffing and NRZI coding.
  task automatic build(int eff);
    int run = 0;
    logic lvl = 1'b0;
    nsym = 0;
    for (int i = 0; i < eff * 8; i++) begin
      int byt;
      int b;
      byt = (i < 8) ? 8'h80 : pl[i / 8 - 1];
      b = (byt >> (i % 8)) & 1;
      if (b == 0) begin lvl = ~lvl; run = 0; end
      else run++;
      lvl_seq[nsym] = lvl; nsym++;
      if (run == 6) begin
        lvl = ~lvl; run = 0;
        lvl_seq[nsym] = lvl; nsym++;
      end
    end
  endtask

  // Called at a negedge; compares every clock of the packet.
  task automatic send(int req_cnt, int eff, bit poke);
    int  idx = 0;
    bit  seen = 0;
    int  nreq = 0;
    int  last;
    build(eff);
    byte_data  = 8'(pl[0]);
    start      = 1'b1;
    byte_count = CW'(req_cnt);
    last = 42 + 10 * nsym;
    for (int c = 0; c <= last; c++) begin
      logic [5:0] exp;
      string tag;
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (poke && c == 60) begin start = 1'b1; byte_count = 4'd5; end
      if (poke && c == 61) start = 1'b0;
      if (seen) begin idx++; byte_data = 8'(pl[idx]); end
      if (seen && byte_req) expect_int("R7 request longer than one clock", 1, 0);
      seen = byte_req;
      if (byte_req) nreq++;
      if (c == 0) begin
        exp = 6'b001000; tag = "R2 arm";
      end else if (c <= 10) begin
        exp = 6'b101000; tag = "R2 lead";
      end else if (c < 11 + 10 * nsym) begin
        logic lv;
        lv  = lvl_seq[(c - 11) / 10];
        exp = {1'b1, lv, ~lv, 3'b000};
        tag = poke ? "R11 R3 R5 R6" : "R3 R4 R5 R6";
      end else if (c < 31 + 10 * nsym) begin
        exp = 6'b100000; tag = "R8 se0";
      end else if (c < 41 + 10 * nsym) begin
        exp = 6'b101000; tag = "R8 eop J";
      end else if (c == 41 + 10 * nsym) begin
        exp = {3'b000, 1'b1, (eff > 2), 1'b0}; tag = "R9 R10 done";
      end else begin
        exp = 6'b000000; tag = "R9 after";
      end
      expect_vec(tag, c, {usb_oe, usb_dp, usb_dm, done, addr_commit, 1'b0}, exp);
    end
    expect_int(poke ? "R11 R4 R7 fetch count" : "R4 R7 fetch count", nreq, eff - 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; byte_count = '0; byte_data = '0;
    repeat (3) @(negedge clk);
    expect_vec("R1 in reset", 0, {usb_oe, usb_dp, usb_dm, done, addr_commit, byte_req}, 6'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_vec("R1 after reset", 0, {usb_oe, usb_dp, usb_dm, done, addr_commit, byte_req}, 6'b0);

    // Handshake packet: no address commit (R10).
    pl[0] = 8'hD2;
    send(2, 2, 0);
    // Short data packet: address commit (R10).
    pl[0] = 8'h69; pl[1] = 8'h00;
    send(3, 3, 0);
    // Long runs of ones across byte boundaries (R6).
    for (int i = 0; i < 16; i++) pl[i] = 8'hFF;
    send(12, 12, 0);
    for (int i = 0; i < 16; i++) pl[i] = 8'h00;
    send(5, 5, 0);
    // Ones right before the end of the packet force a trailing stuffed bit (R6).
    pl[0] = 8'hFC;
    send(2, 2, 0);
    // Clamping (R12).
    for (int i = 0; i < 16; i++) pl[i] = (i * 53 + 7) & 8'hFF;
    send(1, 2, 0);
    send(0, 2, 0);
    send(15, 12, 0);
    // Start while busy is ignored (R11).
    send(4, 4, 1);
    // Every single payload byte value.
    for (int v = 0; v < 256; v++) begin
      pl[0] = v;
      send(2, 2, 0);
    end
    // Every legal count.
    for (int n = 2; n <= 12; n++) begin
      for (int i = 0; i < 16; i++) pl[i] = (i * 37 + n * 11) & 8'hFF;
      send(n, n, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R3 watchdog got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule